// File: doc/BRIEF.md
# Strobe-Launched Four-Function ALU

This block is a small clocked arithmetic-logic unit for unsigned 8-bit data. A single-cycle start pulse launches an operation. On that launch edge the unit latches both operands and a 2-bit function code. The answer then appears on a 16-bit result bus at a fixed point: two rising edges after the launch edge. The four functions are addition, multiplication, bitwise OR and bitwise AND.

The result bus keeps showing the last completed answer until another operation completes. Callers therefore sample it whenever convenient once the latency has passed. There is no handshake. The caller keeps to the fixed latency and issues the next start only once the previous result has been delivered. An active-high synchronous reset empties the pipeline and zeroes the result.

Top module: `strobe_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the pipeline is emptied and `resultOut` reads 0 after that edge.
- R2: Function code 0 (add) yields the 9-bit unsigned sum of `opA` and `opB`, carry included, in `resultOut[8:0]`, and zeros in `resultOut[15:9]`.
- R3: Function code 1 (multiply) yields the full unsigned 16-bit product of `opA` and `opB` on all of `resultOut`.
- R4: Function code 2 (OR) yields `opA | opB` in `resultOut[7:0]` and zeros in `resultOut[15:8]`.
- R5: Function code 3 (AND) yields `opA & opB` in `resultOut[7:0]` and zeros in `resultOut[15:8]`.
- R6: If `startPulse` is high at launch edge E0, the new result appears right after the second following rising edge (E2). After E0 and after E1, `resultOut` still shows the previous value.
- R7: `opA`, `opB` and `opSel` are taken only at the launch edge. Changing them afterwards does not alter the pending result.
- R8: When no operation completes at an edge, `resultOut` keeps its value, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous reset |
| startPulse | input | 1 | One-cycle launch strobe |
| opSel | input | 2 | Function code: 0 add, 1 multiply, 2 OR, 3 AND |
| opA | input | 8 | First unsigned operand |
| opB | input | 8 | Second unsigned operand |
| resultOut | output | 16 | Registered result, held until the next completion |

## Verification
A launch at edge E0 moves the result bus only after edge E2, which is two edges later. The bench raises the strobe before E0 and drops it right after E0, when it also scrambles the operands and function code. It reads the bus at the falling edge after E1, where the previous value is still expected. It reads it again at the falling edge after E2, where the new value is expected. In the hold and reset tests it keeps sampling at falling edges for several idle cycles, so no read ever races the edge that updates the register.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_MUL = 2'd1,
    FN_OR  = 2'd2,
    FN_AND = 2'd3
  } aluFn_e;

  // Strobes from control to datapath, one per pipeline step
  typedef struct packed {
    logic clearAll;   // synchronous reset of every datapath register
    logic captureEn;  // latch operands and function code
    logic computeEn;  // evaluate the selected function
    logic commitEn;   // move evaluated value to the result bus
  } aluCtrl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
#(
  parameter int STAGES = 2  // edges between launch and result
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     startPulse,
  output aluCtrl_t ctrl
);

  // Token shift register: bit k set means the launched op is k+1 edges old
  logic [STAGES-1:0] tokenQ;

  always_ff @(posedge clk) begin
    if (rst) tokenQ <= '0;
    else     tokenQ <= {tokenQ[STAGES-2:0], startPulse};
  end

  always_comb begin
    ctrl.clearAll  = rst;
    ctrl.captureEn = startPulse && !rst;
    ctrl.computeEn = tokenQ[0];
    ctrl.commitEn  = tokenQ[STAGES-1];
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int RES_W = 2 * DATA_W,
  localparam int SUM_W = DATA_W + 1
) (
  input  logic              clk,
  input  aluCtrl_t          ctrl,
  input  logic [1:0]        opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [RES_W-1:0]  resultOut
);

  logic [DATA_W-1:0] capA, capB;
  aluFn_e            capFn;
  logic [RES_W-1:0]  evalNext, evalQ, resultQ;
  logic [SUM_W-1:0]  sumVal;
  logic [RES_W-1:0]  prodVal;

  // Operand capture on the launch edge
  always_ff @(posedge clk) begin
    if (ctrl.clearAll) begin
      capA  <= '0;
      capB  <= '0;
      capFn <= FN_ADD;
    end else if (ctrl.captureEn) begin
      capA  <= opA;
      capB  <= opB;
      capFn <= aluFn_e'(opSel);
    end
  end

  assign sumVal  = SUM_W'(capA) + SUM_W'(capB);
  assign prodVal = RES_W'(capA) * RES_W'(capB);

  always_comb begin
    unique case (capFn)
      FN_ADD:  evalNext = RES_W'(sumVal);
      FN_MUL:  evalNext = prodVal;
      FN_OR:   evalNext = RES_W'(capA | capB);
      FN_AND:  evalNext = RES_W'(capA & capB);
      default: evalNext = '0;
    endcase
  end

  // Evaluation stage, then the held result register
  always_ff @(posedge clk) begin
    if (ctrl.clearAll) begin
      evalQ   <= '0;
      resultQ <= '0;
    end else begin
      if (ctrl.computeEn) evalQ   <= evalNext;
      if (ctrl.commitEn)  resultQ <= evalQ;
    end
  end

  assign resultOut = resultQ;

endmodule

// File: rtl/strobe_alu.sv
module strobe_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int RES_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startPulse,
  input  logic [1:0]        opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [RES_W-1:0]  resultOut
);

  aluCtrl_t ctrl;

  alu_ctrl #(.STAGES(2)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .startPulse (startPulse),
    .ctrl       (ctrl)
  );

  alu_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .ctrl      (ctrl),
    .opSel     (opSel),
    .opA       (opA),
    .opB       (opB),
    .resultOut (resultOut)
  );

endmodule

// File: rtl/strobe_alu_sva.sv
module strobe_alu_sva #(
  parameter int DATA_W = 8,
  localparam int RES_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              startPulse,
  input logic [1:0]        opSel,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [RES_W-1:0]  resultOut
);

  logic              age1, age2;
  logic [DATA_W-1:0] refA, refB;
  logic [1:0]        refFn;

  always_ff @(posedge clk) begin
    if (rst) begin
      age1 <= 1'b0; age2 <= 1'b0;
      refA <= '0; refB <= '0; refFn <= '0;
    end else begin
      age1 <= startPulse;
      age2 <= age1;
      if (startPulse) begin
        refA <= opA; refB <= opB; refFn <= opSel;
      end
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> resultOut == '0);

  a_r2_add: assert property (@(posedge clk) disable iff (rst)
    (age2 && refFn == 2'd0) |=> resultOut == RES_W'({1'b0, refA} + {1'b0, refB}));

  a_r3_mul: assert property (@(posedge clk) disable iff (rst)
    (age2 && refFn == 2'd1) |=> resultOut == RES_W'(refA) * RES_W'(refB));

  a_r4_or: assert property (@(posedge clk) disable iff (rst)
    (age2 && refFn == 2'd2) |=> resultOut == RES_W'(refA | refB));

  a_r5_and: assert property (@(posedge clk) disable iff (rst)
    (age2 && refFn == 2'd3) |=> resultOut == RES_W'(refA & refB));

  // R6 and R8: outside the completing edge the bus does not move
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !age2 |=> $stable(resultOut));

endmodule

bind strobe_alu strobe_alu_sva #(.DATA_W(DATA_W)) sva_i (
  .clk        (clk),
  .rst        (rst),
  .startPulse (startPulse),
  .opSel      (opSel),
  .opA        (opA),
  .opB        (opB),
  .resultOut  (resultOut)
);

// File: tb/strobe_alu_tb_top.sv
module strobe_alu_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 9;
  // {fn[1:0], a[7:0], b[7:0], expected[15:0]}
  localparam logic [33:0] VECS [NVEC] = '{
    {2'd0, 8'hFF, 8'hFF, 16'h01FE},
    {2'd0, 8'h80, 8'h7F, 16'h00FF},
    {2'd0, 8'h01, 8'hFF, 16'h0100},
    {2'd1, 8'hFF, 8'hFF, 16'hFE01},
    {2'd1, 8'h12, 8'h34, 16'h03A8},
    {2'd1, 8'h00, 8'hAB, 16'h0000},
    {2'd2, 8'hA5, 8'h5A, 16'h00FF},
    {2'd3, 8'hF0, 8'h3C, 16'h0030},
    {2'd3, 8'hFF, 8'hFF, 16'h00FF}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        startPulse;
  logic [1:0]  opSel;
  logic [7:0]  opA, opB;
  logic [15:0] resultOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_alu dut_i (
    .clk(clk), .rst(rst), .startPulse(startPulse),
    .opSel(opSel), .opA(opA), .opB(opB), .resultOut(resultOut)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  function automatic string reqOf(input logic [1:0] fn);
    case (fn)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // Launch one op, scramble inputs after launch (R7), check latency (R6)
  task automatic runOp(input logic [1:0] fn, input logic [7:0] a, input logic [7:0] b,
                       input logic [15:0] exp);
    logic [15:0] prev;
    @(negedge clk);
    prev = resultOut;
    opSel = fn; opA = a; opB = b; startPulse = 1'b1;
    @(posedge clk);                 // launch edge E0
    @(negedge clk);
    startPulse = 1'b0;
    opSel = ~fn; opA = ~a; opB = 8'($urandom);
    check("R6", resultOut, prev);
    @(posedge clk);                 // E1
    @(negedge clk);
    check("R6", resultOut, prev);
    @(posedge clk);                 // E2
    @(negedge clk);
    check({reqOf(fn), "/R7"}, resultOut, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; startPulse = 1'b0; opSel = 2'd0; opA = '0; opB = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", resultOut, 16'h0000);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++)
      runOp(VECS[i][33:32], VECS[i][31:24], VECS[i][23:16], VECS[i][15:0]);

    // R8: idle with wiggling inputs, result held
    runOp(2'd1, 8'h0F, 8'h11, 16'h00FF);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      opA = 8'($urandom); opB = 8'($urandom); opSel = 2'($urandom);
      check("R8", resultOut, 16'h00FF);
    end

    // R1: reset clears held result, pipeline emptied
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", resultOut, 16'h0000);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", resultOut, 16'h0000);

    // R1: reset right after launch cancels the pending op
    @(negedge clk);
    opSel = 2'd1; opA = 8'h20; opB = 8'h20; startPulse = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startPulse = 1'b0; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", resultOut, 16'h0000);

    // Boundary after reset: add carry out lands in bit 8
    runOp(2'd0, 8'hFF, 8'h01, 16'h0100);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule